// File: doc/BRIEF.md
# Fixed-Point Second-Order Integrator Step Engine

This block advances a coupled pair of state variables, u and y, along an independent variable x. It does this with a fixed recurrence in signed Q8.8 fixed point. A single start pulse loads the initial x, y and u, the step dx and the end point a. The engine then repeats one update step for as long as x is below a. Each step does the following:

- it moves x forward by dx;
- it adds the increment u·dx to y;
- it removes 3·x·u·dx from u.

Every product in a step is formed from the values held before that step, and x, y and u are all replaced together at the end of the step.

The arithmetic is time-shared under a fixed four-slot schedule. There are two multipliers and one adder/subtractor. The factor of three is produced on the adder as twice a value plus the value, so no third multiplier is needed. When x has reached or passed a, done pulses for one cycle and the final x, y and u stay on the registered outputs until the next start.

Top module: `integ_top`

## Requirements
- R1: Values are W=16-bit two's complement with FRAC=8 fraction bits. Each multiply keeps bits [23:8] of the full 32-bit signed product, which rounds toward minus infinity. Each sum wraps modulo 2^16.
- R2: After a step, x equals the old x plus dx, wrapped.
- R3: After a step, y equals the old y plus mul(u, dx), taken with the old u.
- R4: After a step, u equals the old u minus (2p + p), where p = mul(mul(x, dx), u) on old values and the triple wraps.
- R5: x_out, y_out and u_out change only on a start that loads them or on the last cycle of a step, where all three update together.
- R6: A new step begins only while x < a (signed), with x taken after the previous commit. Whenever done is high, x_out >= a_init as loaded.
- R7: If x_init >= a_init at start, no step runs. done is high right after the edge that samples start, and the outputs show the loaded initial values.
- R8: Each step takes exactly four cycles. After N >= 1 steps, done is high right after the edge 4N edges after the edge that sampled start.
- R9: done is a one-cycle pulse after which the block is idle. The outputs then hold their values until the next start.
- R10: start is ignored while a run is in progress. The inputs presented with it have no effect on the results.
- R11: Reset, synchronous and active high, clears done and sets x_out, y_out and u_out to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load operands and begin; sampled only when idle |
| x_init | input | 16 | Initial x, Q8.8 |
| y_init | input | 16 | Initial y, Q8.8 |
| u_init | input | 16 | Initial u, Q8.8 |
| dx_in | input | 16 | Step size, Q8.8 |
| a_init | input | 16 | End point for x, Q8.8 |
| x_out | output | 16 | Current x (registered) |
| y_out | output | 16 | Current y (registered) |
| u_out | output | 16 | Current u (registered) |
| done | output | 1 | One-cycle pulse when the loop ends |

## Verification
The checks presume that dx is positive and that a plus dx fits in a signed 16-bit word. Under those conditions x climbs monotonically to a without wrapping past it, so a run always terminates and the limit checks around done stay meaningful. The stimulus sweeps only positive steps and end points well below the top of the range, which keeps every run inside that assumption. The sweep still lets u and y wrap freely, because their wrap is part of the specified arithmetic.

// File: rtl/integ_pkg.sv
package integ_pkg;
  // Schedule slots; one step walks MUL -> MAC -> TRIPLE -> COMMIT
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_MUL    = 3'd1,
    ST_MAC    = 3'd2,
    ST_TRIPLE = 3'd3,
    ST_COMMIT = 3'd4
  } phase_t;
endpackage

// File: rtl/fx_mul.sv
module fx_mul #(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] p
);
  localparam int PW = 2 * W;
  logic signed [PW-1:0] full;
  assign full = a * b;
  // keep the middle W bits: arithmetic shift, then truncate
  assign p = W'(full >>> FRAC);
endmodule

// File: rtl/fx_addsub.sv
module fx_addsub #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  input  logic                sub,
  output logic signed [W-1:0] s
);
  assign s = sub ? (a - b) : (a + b);
endmodule

// File: rtl/integ_ctrl.sv
module integ_ctrl
  import integ_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   go_init,
  input  logic   go_next,
  output phase_t phase,
  output logic   load,
  output logic   done
);
  assign load = (phase == ST_IDLE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        ST_IDLE: begin
          if (start) begin
            if (go_init) phase <= ST_MUL;
            else         done  <= 1'b1;
          end
        end
        ST_MUL:    phase <= ST_MAC;
        ST_MAC:    phase <= ST_TRIPLE;
        ST_TRIPLE: phase <= ST_COMMIT;
        ST_COMMIT: begin
          if (go_next) begin
            phase <= ST_MUL;
          end else begin
            phase <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/integ_top.sv
module integ_top
  import integ_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] x_init,
  input  logic [W-1:0] y_init,
  input  logic [W-1:0] u_init,
  input  logic [W-1:0] dx_in,
  input  logic [W-1:0] a_init,
  output logic [W-1:0] x_out,
  output logic [W-1:0] y_out,
  output logic [W-1:0] u_out,
  output logic         done
);
  // architectural state
  logic signed [W-1:0] x_q, y_q, u_q, dx_q, a_q;
  // values spanning schedule slots
  logic signed [W-1:0] ud_q, xd_q, xn_q, yn_q, xud_q, t3_q;

  phase_t phase;
  logic   load, go_init, go_next, busy, commit;

  // shared functional units
  logic signed [W-1:0] m0_a, m0_b, m0_p, m1_p;
  logic signed [W-1:0] ad_a, ad_b, ad_s;
  logic                ad_sub;

  assign go_init = $signed(x_init) < $signed(a_init);
  assign go_next = xn_q < a_q;
  assign busy    = (phase != ST_IDLE);
  assign commit  = (phase == ST_COMMIT);

  integ_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .go_init (go_init),
    .go_next (go_next),
    .phase   (phase),
    .load    (load),
    .done    (done)
  );

  fx_mul #(.W(W), .FRAC(FRAC)) u_mul0 (.a(m0_a), .b(m0_b), .p(m0_p));
  fx_mul #(.W(W), .FRAC(FRAC)) u_mul1 (.a(x_q),  .b(dx_q), .p(m1_p));
  fx_addsub #(.W(W)) u_add (.a(ad_a), .b(ad_b), .sub(ad_sub), .s(ad_s));

  // operand steering per slot
  always_comb begin
    m0_a   = '0;
    m0_b   = '0;
    ad_a   = '0;
    ad_b   = '0;
    ad_sub = 1'b0;
    case (phase)
      ST_MUL: begin
        m0_a = u_q;  m0_b = dx_q;             // u*dx
        ad_a = x_q;  ad_b = dx_q;             // x+dx
      end
      ST_MAC: begin
        m0_a = xd_q; m0_b = u_q;              // (x*dx)*u
        ad_a = y_q;  ad_b = ud_q;             // y+u*dx
      end
      ST_TRIPLE: begin
        ad_a = {xud_q[W-2:0], 1'b0};          // 2p
        ad_b = xud_q;                         // +p
      end
      ST_COMMIT: begin
        ad_a = u_q;  ad_b = t3_q; ad_sub = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q   <= '0; y_q  <= '0; u_q  <= '0;
      dx_q  <= '0; a_q  <= '0;
      ud_q  <= '0; xd_q <= '0; xn_q <= '0;
      yn_q  <= '0; xud_q <= '0; t3_q <= '0;
    end else begin
      if (load) begin
        x_q  <= x_init;
        y_q  <= y_init;
        u_q  <= u_init;
        dx_q <= dx_in;
        a_q  <= a_init;
      end
      case (phase)
        ST_MUL: begin
          ud_q <= m0_p;
          xd_q <= m1_p;
          xn_q <= ad_s;
        end
        ST_MAC: begin
          xud_q <= m0_p;
          yn_q  <= ad_s;
        end
        ST_TRIPLE: t3_q <= ad_s;
        ST_COMMIT: begin
          x_q <= xn_q;
          y_q <= yn_q;
          u_q <= ad_s;
        end
        default: ;
      endcase
    end
  end

  assign x_out = x_q;
  assign y_out = y_q;
  assign u_out = u_q;
endmodule

// File: rtl/integ_checks.sv
module integ_checks #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         done,
  input logic         busy,
  input logic         commit,
  input logic [W-1:0] x_out,
  input logic [W-1:0] y_out,
  input logic [W-1:0] u_out,
  input logic [W-1:0] dx_q,
  input logic [W-1:0] a_q
);
  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    (!commit && !(!busy && start)) |=> ($stable(x_out) && $stable(y_out) && $stable(u_out))); // R5

  AST_X_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    commit |=> (x_out == W'($past(x_out) + $past(dx_q)))); // R2

  AST_BUSY_BELOW_END: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($signed(x_out) < $signed(a_q))); // R6

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    done |-> ($signed(x_out) >= $signed(a_q))); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(a_q) && $stable(dx_q))); // R10
endmodule

bind integ_top integ_checks #(.W(W)) u_checks (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .done   (done),
  .busy   (busy),
  .commit (commit),
  .x_out  (x_out),
  .y_out  (y_out),
  .u_out  (u_out),
  .dx_q   (dx_q),
  .a_q    (a_q)
);

// File: tb/test_integ_top.sv
module test_integ_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [W-1:0] x_init, y_init, u_init, dx_in, a_init;
  logic [W-1:0] x_out, y_out, u_out;
  logic         done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  integ_top i_integ_top (
    .clk(clk), .rst(rst), .start(start),
    .x_init(x_init), .y_init(y_init), .u_init(u_init),
    .dx_in(dx_in), .a_init(a_init),
    .x_out(x_out), .y_out(y_out), .u_out(u_out), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Q8.8 multiply per R1: bits [23:8] of the signed 32-bit product
  function automatic logic [15:0] qmul(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] p;
    p = $signed(a) * $signed(b);
    return p[23:8];
  endfunction

  task automatic run(input logic [15:0] x0, y0, u0, dx, a, input bit poke);
    logic [15:0] ex, ey, eu, ud, xd, xud, t3;
    int n, cyc;
    ex = x0; ey = y0; eu = u0; n = 0;
    while ($signed(ex) < $signed(a) && n < 5000) begin
      ud  = qmul(eu, dx);
      xd  = qmul(ex, dx);
      xud = qmul(xd, eu);
      t3  = (xud << 1) + xud;
      ex  = ex + dx;
      ey  = ey + ud;
      eu  = eu - t3;
      n++;
    end
    @(negedge clk);
    x_init = x0; y_init = y0; u_init = u0; dx_in = dx; a_init = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    x_init = 16'h1234; y_init = 16'h4321; u_init = 16'h0F0F; dx_in = 16'h0001; a_init = 16'h7000;
    cyc = 0;
    while (!done && cyc < 30000) begin
      if (n > 0 && cyc == 2) chk("R5 x held mid-step", x_out, x0);
      start = (poke && n > 0 && cyc == 1);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (!done) chk("R8 done never seen", 0, 1);
    if (n == 0) chk("R7 latency", cyc, 0);
    else        chk("R8 latency", cyc, 4 * n);
    chk("R2 x", x_out, ex);
    chk("R3 y", y_out, ey);
    chk("R4 u", u_out, eu);
    if (poke && n > 0) chk("R10 start ignored while busy", {x_out, u_out}, {ex, eu});
    if (n == 0) chk("R7 initial values", {x_out, y_out}, {x0, y0});
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
    chk("R9 outputs held", {x_out, y_out}, {ex, ey});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] dxs [4];
    logic [15:0] xs  [3];
    logic [15:0] as  [3];
    logic [15:0] us  [3];
    dxs = '{16'h0008, 16'h0020, 16'h0055, 16'h0100};
    xs  = '{16'hFE00, 16'h0000, 16'h0180};
    as  = '{16'hFF00, 16'h0100, 16'h0300};
    us  = '{16'h0100, 16'hFF80, 16'h0A00};
    rst = 1'b1; start = 1'b0;
    x_init = '0; y_init = '0; u_init = '0; dx_in = '0; a_init = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset done", done, 0);
    chk("R11 reset outputs", {x_out, y_out, u_out}, 48'h0);
    rst = 1'b0;
    // R1 floor truncation, hand computed: u=-1/256, dx=0.5 -> u*dx = -1/256
    run(16'h0000, 16'h0000, 16'hFFFF, 16'h0080, 16'h0080, 1'b0);
    chk("R1 negative product floors", y_out, 16'hFFFF);
    // R1 exact: u=1.0, dx=0.5 -> y gains 0.5
    run(16'h0000, 16'h0000, 16'h0100, 16'h0080, 16'h0080, 1'b0);
    chk("R1 exact product", y_out, 16'h0080);
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 3; j++)
        for (int k = 0; k < 3; k++)
          for (int m = 0; m < 3; m++)
            run(xs[j], 16'(16'h0040 * (i + m)), us[m], dxs[i], as[k], ((i + j + k + m) % 2) == 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule